// File: doc/BRIEF.md
# Shadowed PWM Channel with Prescaler

This block is one pulse-width modulation channel. A register interface presents the period, active-end and divider values and two 2-bit level codes, and pulses an arm strobe to capture them into staging registers. The channel then runs from working copies of those values. A selectable prescaler paces a 16-bit period counter. The output sits in its active phase from the start of each period until the counter reaches the active-end value. It sits in its inactive phase for the rest of the period.

Staged values move into the working registers only when a new period begins. Settings can therefore be rewritten at any time without cutting a pulse short. While the channel is disabled, the counter and prescaler are held at zero and the working registers follow the staged ones. Enabling the channel therefore starts a fresh period with the latest staged values. Each phase has its own level code. The code selects a high drive, a low drive, or a request to release the pad.

Top module: `pwm_shadow_chan`

## Requirements
- R1: The 3-bit divider select `cfg_div` gives a prescale of 2^s. For select values 0 to 7, s is 0, 1, 2, 3, 4, 6, 8 and 10 in that order, so the counter advances once every 1, 2, 4, 8, 16, 64, 256 or 1024 clock cycles.
- R2: The period counter counts from 0 up to the working period value, then returns to 0. One output period therefore lasts (period+1) prescaler ticks.
- R3: While enabled, the output is in its active phase while the counter is below the working active-end value, and in its inactive phase otherwise.
- R4: A level code of 3 drives `pwm_out` high and a code of 2 drives it low. `cfg_act_lvl` applies in the active phase and `cfg_idle_lvl` applies in the inactive phase.
- R5: A level code of 0 or 1 in the current phase sets `pwm_hiz` to 1 and forces `pwm_out` to 0. Codes 2 and 3 leave `pwm_hiz` at 0.
- R6: A cycle with `arm` high captures all configuration inputs into staging. While enabled, the staged values reach the working registers only at the clock edge where the counter wraps to 0.
- R7: While `en` is low, the counter and prescaler stay at 0, the output shows the inactive-phase level, and the staged values are copied into the working registers every cycle. After `en` rises, counting starts from 0.
- R8: An active-end of 0 keeps the output in the inactive phase for the whole period. An active-end greater than the period keeps it in the active phase for the whole period.
- R9: After reset, the staged and working values are: period all ones, active-end 0, active code 3, inactive code 2 and divider 0. The output is therefore 0 with `pwm_hiz` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| arm | input | 1 | Capture strobe for the configuration inputs |
| cfg_period | input | 16 | Last count value of the period |
| cfg_act_end | input | 16 | Count at which the active phase ends |
| cfg_act_lvl | input | 2 | Level code for the active phase |
| cfg_idle_lvl | input | 2 | Level code for the inactive phase |
| cfg_div | input | 3 | Prescaler select |
| pwm_out | output | 1 | Output data value |
| pwm_hiz | output | 1 | Request to release the pad |

## Verification
The hardest case to reach is a rewrite that lands in the middle of a period. The counter is not visible at the ports, so the bench has to place the arm strobe at a known count. A directed sequence enables the channel with a divide-by-1 prescaler and arms a conflicting active-end a few cycles later. It then checks that the old pulse shape holds until the wrap. Random rounds then mix arm strobes, enable toggles and all eight divider selects. A cycle-level reference model built from the requirements checks every cycle of these rounds.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

   // Largest prescale shift; sets the width of the prescaler accumulator.
   localparam int unsigned MAX_SHIFT = 10;
   localparam int unsigned SEL_W     = 3;

   typedef enum logic [1:0] {
      LVL_Z0   = 2'd0,
      LVL_Z1   = 2'd1,
      LVL_LOW  = 2'd2,
      LVL_HIGH = 2'd3
   } lvl_code_e;

   typedef struct packed {
      lvl_code_e act;
      lvl_code_e idle;
   } lvl_pair_t;

   // Non-uniform shift table: linear up to 4, then steps of two.
   function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
      int unsigned s;
      s = int'(sel);
      return (s < 5) ? s : (2 * s - 4);
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_shadow_pkg::*;
#(
   parameter int unsigned ACC_W = MAX_SHIFT
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] limit;

   initial assert (ACC_W >= MAX_SHIFT)
      else $error("pwm_prescaler: ACC_W too narrow for largest shift");

   always_comb begin
      limit = ACC_W'((32'd1 << div_shift(div_sel)) - 32'd1);
      tick  = run && (acc_q == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             acc_q <= '0;
      else if (!run || tick)  acc_q <= '0;
      else                    acc_q <= acc_q + 1'b1;
   end

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   assign wrap = run && tick && (cnt == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || wrap) cnt <= '0;
      else if (tick)        cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pwm_level_map.sv
module pwm_level_map
   import pwm_shadow_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
)(
   input  logic      clk,
   input  logic      rst_n,
   input  lvl_code_e code,
   output logic      out,
   output logic      hiz
);

   logic out_d, hiz_d;

   always_comb begin
      hiz_d = (code == LVL_Z0) || (code == LVL_Z1);
      out_d = (code == LVL_HIGH);
   end

   generate
      if (OUT_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out <= 1'b0;
               hiz <= 1'b0;
            end else begin
               out <= out_d;
               hiz <= hiz_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out = out_d;
         assign hiz = hiz_d;
      end
   endgenerate

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
   import pwm_shadow_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DIV_W   = 3,
   parameter bit          OUT_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             arm,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_act_end,
   input  logic [1:0]       cfg_act_lvl,
   input  logic [1:0]       cfg_idle_lvl,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             pwm_out,
   output logic             pwm_hiz
);

   localparam logic [CNT_W-1:0] RST_PERIOD = '1;
   localparam lvl_pair_t        RST_LVL    = '{act: LVL_HIGH, idle: LVL_LOW};

   initial assert (CNT_W >= 2) else $error("pwm_shadow_chan: CNT_W must be >= 2");
   initial assert (DIV_W == SEL_W) else $error("pwm_shadow_chan: DIV_W must match shift table");

   // Staging registers, written by arm.
   logic [CNT_W-1:0] s_period, s_act_end;
   lvl_pair_t        s_lvl;
   logic [DIV_W-1:0] s_div;
   // Working registers, used by the counter and output.
   logic [CNT_W-1:0] w_period, w_act_end;
   lvl_pair_t        w_lvl;
   logic [DIV_W-1:0] w_div;

   logic             pre_tick, wrap;
   logic [CNT_W-1:0] cnt;
   logic             in_active;
   lvl_code_e        cur_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_period  <= RST_PERIOD;
         s_act_end <= '0;
         s_lvl     <= RST_LVL;
         s_div     <= '0;
      end else if (arm) begin
         s_period  <= cfg_period;
         s_act_end <= cfg_act_end;
         s_lvl     <= '{act: lvl_code_e'(cfg_act_lvl), idle: lvl_code_e'(cfg_idle_lvl)};
         s_div     <= cfg_div;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_period  <= RST_PERIOD;
         w_act_end <= '0;
         w_lvl     <= RST_LVL;
         w_div     <= '0;
      end else if (!en || wrap) begin
         w_period  <= s_period;
         w_act_end <= s_act_end;
         w_lvl     <= s_lvl;
         w_div     <= s_div;
      end
   end

   pwm_prescaler #(.ACC_W(MAX_SHIFT)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en),
      .div_sel (w_div),
      .tick    (pre_tick)
   );

   pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en),
      .tick   (pre_tick),
      .period (w_period),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   always_comb begin
      in_active = en && (cnt < w_act_end);
      cur_code  = in_active ? w_lvl.act : w_lvl.idle;
   end

   pwm_level_map #(.OUT_REG(OUT_REG)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (cur_code),
      .out   (pwm_out),
      .hiz   (pwm_hiz)
   );

endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             tick,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] w_period,
   input logic [DIV_W-1:0] w_div,
   input logic             pwm_out,
   input logic             pwm_hiz
);

   // R1: select 0 means the counter advances every enabled cycle.
   p_div1_every_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && w_div == '0) |-> tick);

   // R2: after a wrap the counter restarts at zero.
   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   // R2: the counter never passes the working period.
   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= w_period));

   // R5: a release request never comes with a driven high.
   p_hiz_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_hiz |-> !pwm_out);

   // R6: working period only changes at a wrap or while disabled.
   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> (!en || $stable(w_period)));

   // R7: disabled channel holds its counter at zero.
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!en || cnt == '0));

endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .tick     (pre_tick),
   .wrap     (wrap),
   .cnt      (cnt),
   .w_period (w_period),
   .w_div    (w_div),
   .pwm_out  (pwm_out),
   .pwm_hiz  (pwm_hiz)
);

// File: tb/pwm_shadow_chan_tb_top.sv
module pwm_shadow_chan_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        arm = 1'b0;
   logic [15:0] cfg_period = '0;
   logic [15:0] cfg_act_end = '0;
   logic [1:0]  cfg_act_lvl = 2'd3;
   logic [1:0]  cfg_idle_lvl = 2'd2;
   logic [2:0]  cfg_div = '0;
   logic        pwm_out, pwm_hiz;

   int checks = 0;
   int fails = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_shadow_chan dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .arm(arm),
      .cfg_period(cfg_period), .cfg_act_end(cfg_act_end),
      .cfg_act_lvl(cfg_act_lvl), .cfg_idle_lvl(cfg_idle_lvl),
      .cfg_div(cfg_div), .pwm_out(pwm_out), .pwm_hiz(pwm_hiz)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int shift_of(input logic [2:0] sel);
      int tbl[8] = '{0, 1, 2, 3, 4, 6, 8, 10};
      return tbl[sel];
   endfunction

   // Reference model, built from the requirements.
   int m_sp, m_sae, m_sa, m_si, m_sd;
   int m_wp, m_wae, m_wa, m_wi, m_wd;
   int m_pre, m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sp = 16'hFFFF; m_sae = 0; m_sa = 3; m_si = 2; m_sd = 0;
         m_wp = 16'hFFFF; m_wae = 0; m_wa = 3; m_wi = 2; m_wd = 0;
         m_pre = 0; m_cnt = 0;
      end else begin
         int nsp, nsae, nsa, nsi, nsd;
         nsp = m_sp; nsae = m_sae; nsa = m_sa; nsi = m_si; nsd = m_sd;
         if (arm) begin
            nsp = cfg_period; nsae = cfg_act_end; nsa = cfg_act_lvl;
            nsi = cfg_idle_lvl; nsd = cfg_div;
         end
         if (!en) begin
            m_pre = 0; m_cnt = 0;
            m_wp = m_sp; m_wae = m_sae; m_wa = m_sa; m_wi = m_si; m_wd = m_sd;
         end else if (m_pre == (1 << shift_of(3'(m_wd))) - 1) begin
            m_pre = 0;
            if (m_cnt == m_wp) begin
               m_cnt = 0;
               m_wp = m_sp; m_wae = m_sae; m_wa = m_sa; m_wi = m_si; m_wd = m_sd;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end else begin
            m_pre = m_pre + 1;
         end
         m_sp = nsp; m_sae = nsae; m_sa = nsa; m_si = nsi; m_sd = nsd;
      end
   end

   always @(negedge clk) begin
      #2;
      if (model_on && rst_n) begin
         int code;
         code = (en && m_cnt < m_wae) ? m_wa : m_wi;
         chk("R2/R3/R4/R7 out", int'(pwm_out), (code == 3) ? 1 : 0);
         chk("R5 hiz", int'(pwm_hiz), (code < 2) ? 1 : 0);
      end
   end

   task automatic stage(input int p, input int ae, input int al, input int il, input int d);
      @(negedge clk);
      cfg_period = 16'(p); cfg_act_end = 16'(ae);
      cfg_act_lvl = 2'(al); cfg_idle_lvl = 2'(il); cfg_div = 3'(d);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int hc, lc;
      void'($urandom(32'd4242));
      // R9: reset state
      #(CLK_PERIOD * 3 + 1);
      chk("R9 out in reset", int'(pwm_out), 0);
      chk("R9 hiz in reset", int'(pwm_hiz), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(2);
      #1;
      chk("R9 out after reset", int'(pwm_out), 0);
      model_on = 1'b1;

      // R1 R2: select 5 (divide by 64), period 3, active end 2
      stage(3, 2, 3, 2, 5);
      wait_cyc(2);
      en = 1'b1;
      #1;
      hc = 0;
      while (pwm_out && hc < 5000) begin hc++; @(negedge clk); #1; end
      chk("R1 active length div64", hc, 128);
      lc = 0;
      while (!pwm_out && lc < 5000) begin lc++; @(negedge clk); #1; end
      chk("R2 inactive length period3", lc, 128);
      en = 1'b0;

      // R4: inverse levels while disabled show the inactive level high
      stage(5, 2, 2, 3, 0);
      wait_cyc(1);
      #1;
      chk("R4 inverse idle high", int'(pwm_out), 1);

      // R5: release code on the inactive phase
      stage(5, 2, 3, 1, 0);
      wait_cyc(1);
      #1;
      chk("R5 hiz code1", int'(pwm_hiz), 1);
      chk("R5 out low with hiz", int'(pwm_out), 0);

      // R6 R8: mid-period arm must wait for the wrap
      stage(9, 5, 3, 2, 0);
      wait_cyc(1);
      en = 1'b1;              // N0
      wait_cyc(3);            // N3
      cfg_act_end = 16'd0; arm = 1'b1;
      @(negedge clk);         // N4
      arm = 1'b0;
      #1;
      chk("R6 old active end kept", int'(pwm_out), 1);
      wait_cyc(6);            // N10, after the wrap
      #1;
      chk("R8 active end 0 inactive", int'(pwm_out), 0);
      wait_cyc(4);
      #1;
      chk("R8 still inactive", int'(pwm_out), 0);
      // R8: active end above period
      stage(3, 7, 3, 2, 0);
      wait_cyc(6);
      #1;
      chk("R8 active end above period", int'(pwm_out), 1);
      en = 1'b0;
      @(negedge clk);
      #1;
      chk("R7 disabled shows inactive", int'(pwm_out), 0);

      // Random rounds, checked every cycle by the model
      for (int r = 0; r < 40; r++) begin
         int div;
         div = (($urandom % 4) == 0) ? int'($urandom % 8) : int'($urandom % 4);
         stage($urandom % 12, $urandom % 15, $urandom % 4, $urandom % 4, div);
         en = (($urandom % 6) != 0);
         for (int c = 0; c < 350; c++) begin
            @(negedge clk);
            if (($urandom % 40) == 0) begin
               cfg_period = 16'($urandom % 12);
               cfg_act_end = 16'($urandom % 15);
               cfg_act_lvl = 2'($urandom % 4);
               cfg_idle_lvl = 2'($urandom % 4);
               cfg_div = 3'($urandom % 4);
               arm = 1'b1;
            end else begin
               arm = 1'b0;
            end
            if (($urandom % 120) == 0) en = ~en;
         end
         arm = 1'b0;
      end

      wait_cyc(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule